// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that raises a flag at a fixed, programmable interval. A prescaler divides the system clock by 16, and each prescaler tick advances a 20-bit interval counter. The counter runs from zero up to a programmed limit P and then wraps. So one interval lasts P+1 ticks, or 16·(P+1) system clocks. Each wrap sets a status flag and adds one to a 12-bit count of elapsed intervals. That count lets software see how many intervals it missed.

Software sees the counter state in two ways. A value register returns the live count and the elapsed-interval count, and reading it acknowledges the flag. An image register returns the same data and leaves all state unchanged. The interrupt line is a level signal that follows the flag, gated by an enable. When the timer is disabled it does not stop at once: it finishes the current interval and halts when the count returns to zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, the mode register, interval count, elapsed-interval count, status flag and prescaler are all zero. `irq_o` is low, and the counter stays at zero until the timer is enabled.
- R2: The mode register is at offset 0x00. Bits 19:0 hold the limit P, bit 24 is the run enable and bit 25 is the interrupt enable. A read returns those fields, and every other bit reads as zero.
- R3: While running, the interval count advances once every 16 clock cycles. The first increment lands 16 cycles after the clock edge that captures the enable.
- R4: The interval count runs 0..P. On the tick after P it returns to 0, sets the status flag (offset 0x04, bit 0) and increments the elapsed-interval count.
- R5: Offset 0x08 returns the interval count in bits 19:0 and the elapsed-interval count in bits 31:20. A read at this offset clears the status flag and the elapsed-interval count.
- R6: Offset 0x0C returns the same layout as offset 0x08, and reading it changes no state.
- R7: Clearing the run enable lets the counter keep counting until it next wraps to 0. The counter then stops there.
- R8: `irq_o` is high exactly when the status flag is set and the interrupt enable is 1.
- R9: The elapsed-interval count saturates at 4095.
- R10: An acknowledging read in the same cycle as a wrap leaves the status flag set and the elapsed-interval count at 1.
- R11: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero. Writes to offsets other than 0x00 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte offset of the register access |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe; a read at offset 0x08 acknowledges |
| rd_data_o | output | 32 | Read data, combinational from `addr_i`; zero when `rd_en_i` is low |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a read strobe held across a clock edge is one access, so an acknowledging read affects state once per edge it spans. They also assume a write to the mode register is the only way to restart a stopped counter. The stimulus drives every strobe for whole cycles, changing it only at falling edges. It places acknowledging reads either well away from prescaler ticks or exactly on a wrap tick, so that each assertion's antecedent is exercised in both forms.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PIT_DIV    = 16;
  localparam int unsigned PIT_CNT_W  = 20;
  localparam int unsigned PIT_PIC_W  = 12;
  localparam int unsigned PIT_DATA_W = 32;
  localparam int unsigned PIT_ADDR_W = 6;

  localparam int unsigned OFS_MODE = 'h00;
  localparam int unsigned OFS_STAT = 'h04;
  localparam int unsigned OFS_ACK  = 'h08;
  localparam int unsigned OFS_IMG  = 'h0C;

  localparam int unsigned RUN_BIT  = 24;
  localparam int unsigned IEN_BIT  = 25;
  localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV = pit_pkg::PIT_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!run_i)          div_q <= '0;
    else if (div_q == LAST)   div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
  parameter int unsigned CNT_W = pit_pkg::PIT_CNT_W,
  parameter int unsigned PIC_W = pit_pkg::PIT_PIC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PIC_W-1:0] pic_o,
  output logic             flag_o
);
  localparam logic [PIC_W-1:0] PIC_MAX = {PIC_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [PIC_W-1:0] pic_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pic_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      // wrap outranks a simultaneous acknowledge
      if (wrap) begin
        flag_q <= 1'b1;
        if (ack_i)                pic_q <= PIC_W'(1);
        else if (pic_q != PIC_MAX) pic_q <= pic_q + 1'b1;
      end else if (ack_i) begin
        flag_q <= 1'b0;
        pic_q  <= '0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pic_o  = pic_q;
  assign flag_o = flag_q;

  assert_hold_between_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == period_i) |=> (cnt_q == '0 && flag_q));
  assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i) |=> (!flag_q && pic_q == '0));
  assert_saturate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pic_q == PIC_MAX && !ack_i) |=> (pic_q == PIC_MAX));
  assert_collide_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && tick_i && cnt_q == period_i) |=> (flag_q && pic_q == PIC_W'(1)));
endmodule

// File: rtl/pit_regfile.sv
module pit_regfile #(
  parameter int unsigned ADDR_W = pit_pkg::PIT_ADDR_W,
  parameter int unsigned DATA_W = pit_pkg::PIT_DATA_W,
  parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int unsigned PIC_W  = pit_pkg::PIT_PIC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PIC_W-1:0]  pic_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  period_o,
  output logic              run_en_o,
  output logic              irq_en_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o
);
  import pit_pkg::*;

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_IMG  = ADDR_W'(OFS_IMG);

  logic [CNT_W-1:0] period_q;
  logic             run_q, ien_q;
  logic             sel_mode, sel_stat, sel_ack, sel_img;
  logic             unused_wdata;

  assign sel_mode = (addr_i == A_MODE);
  assign sel_stat = (addr_i == A_STAT);
  assign sel_ack  = (addr_i == A_ACK);
  assign sel_img  = (addr_i == A_IMG);
  assign unused_wdata = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (wr_en_i && sel_mode) begin
      period_q <= wr_data_i[CNT_W-1:0];
      run_q    <= wr_data_i[RUN_BIT];
      ien_q    <= wr_data_i[IEN_BIT];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (sel_mode) begin
        rd_data_o[CNT_W-1:0] = period_q;
        rd_data_o[RUN_BIT]   = run_q;
        rd_data_o[IEN_BIT]   = ien_q;
      end else if (sel_stat) begin
        rd_data_o[FLAG_BIT]  = flag_i;
      end else if (sel_ack || sel_img) begin
        rd_data_o[CNT_W-1:0]    = cnt_i;
        rd_data_o[CNT_W+:PIC_W] = pic_i;
      end
    end
  end

  assign ack_o    = rd_en_i && sel_ack;
  assign period_o = period_q;
  assign run_en_o = run_q;
  assign irq_en_o = ien_q;

  assert_ro_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel_mode) |=> ($stable(period_q) && $stable(run_q) && $stable(ien_q)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int unsigned DIV    = pit_pkg::PIT_DIV,
  parameter int unsigned ADDR_W = pit_pkg::PIT_ADDR_W,
  parameter int unsigned DATA_W = pit_pkg::PIT_DATA_W,
  parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int unsigned PIC_W  = pit_pkg::PIT_PIC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] period, cnt;
  logic [PIC_W-1:0] pic;
  logic             run_en, irq_en, ack, flag, tick, running;

  // disabled timer keeps going until the count is back at zero
  assign running = run_en || (cnt != '0);

  pit_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running),
    .tick_o (tick)
  );

  pit_interval #(.CNT_W(CNT_W), .PIC_W(PIC_W)) u_intv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ack_i    (ack),
    .period_i (period),
    .cnt_o    (cnt),
    .pic_o    (pic),
    .flag_o   (flag)
  );

  pit_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PIC_W(PIC_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .cnt_i     (cnt),
    .pic_i     (pic),
    .flag_i    (flag),
    .period_o  (period),
    .run_en_o  (run_en),
    .irq_en_o  (irq_en),
    .ack_o     (ack),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = flag && irq_en;

  assert_stopped_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !(wr_en_i && addr_i == ADDR_W'(pit_pkg::OFS_MODE)))
      |=> (cnt == '0 && !tick));
  assert_irq_drops_on_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !tick) |=> !irq_o);
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pit_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [31:0] mode(int p, bit run, bit ien);
    logic [31:0] m = '0;
    m[19:0] = p[19:0];
    m[24] = run;
    m[25] = ien;
    return m;
  endfunction

  function automatic logic [31:0] img(int pic, int cnt);
    return {pic[11:0], cnt[19:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start at a falling edge
  task automatic wr(logic [5:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic hold_rd(logic [5:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    do_reset();
    peek(6'h00, d); chk("R1 mode", d, 32'h0);
    peek(6'h04, d); chk("R1 status", d, 32'h0);
    peek(6'h0C, d); chk("R1 image", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    idle(40);
    peek(6'h0C, d); chk("R1 stays stopped", d, 32'h0);
  endtask

  task automatic test_tick();
    logic [31:0] d;
    do_reset();
    wr(6'h00, 32'hFCF0_0000 | mode(100, 1, 0));
    peek(6'h00, d); chk("R2 mode readback", d, mode(100, 1, 0));
    idle(15);
    peek(6'h0C, d); chk("R3 before first tick", d, img(0, 0));
    idle(1);
    peek(6'h0C, d); chk("R3 first tick", d, img(0, 1));
    idle(16);
    peek(6'h0C, d); chk("R3 second tick", d, img(0, 2));
  endtask

  task automatic test_period();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(2, 1, 0));
    idle(47);
    peek(6'h0C, d); chk("R4 at limit", d, img(0, 2));
    peek(6'h04, d); chk("R4 flag before wrap", d, 32'h0);
    idle(1);
    peek(6'h0C, d); chk("R4 after wrap", d, img(1, 0));
    peek(6'h04, d); chk("R4 flag set", d, 32'h1);
    chk("R8 irq masked", {31'h0, irq}, 32'h0);
    wr(6'h00, mode(2, 1, 1));
    chk("R8 irq on", {31'h0, irq}, 32'h1);
    hold_rd(6'h08, d); chk("R5 ack value", d, img(1, 0));
    chk("R8 irq off after ack", {31'h0, irq}, 32'h0);
  endtask

  task automatic test_ack_image();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(4, 1, 0));
    idle(200);
    peek(6'h0C, d); chk("R6 image", d, img(2, 2));
    hold_rd(6'h0C, d); chk("R6 image held read", d, img(2, 2));
    peek(6'h04, d); chk("R6 flag kept", d, 32'h1);
    peek(6'h0C, d); chk("R6 count kept", d, img(2, 2));
    hold_rd(6'h08, d); chk("R5 ack value", d, img(2, 2));
    peek(6'h04, d); chk("R5 flag cleared", d, 32'h0);
    peek(6'h0C, d); chk("R5 count cleared", d, img(0, 2));
  endtask

  task automatic test_disable();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(9, 1, 0));
    idle(48);
    peek(6'h0C, d); chk("R7 running", d, img(0, 3));
    wr(6'h00, mode(9, 0, 0));
    idle(110);
    peek(6'h0C, d); chk("R7 still counting", d, img(0, 9));
    peek(6'h04, d); chk("R7 no flag yet", d, 32'h0);
    idle(1);
    peek(6'h0C, d); chk("R7 wrapped", d, img(1, 0));
    peek(6'h04, d); chk("R7 flag on final wrap", d, 32'h1);
    idle(64);
    peek(6'h0C, d); chk("R7 stopped", d, img(1, 0));
  endtask

  task automatic test_saturate();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(0, 1, 0));
    idle(16 * 4100);
    peek(6'h0C, d); chk("R9 saturated", d, img(4095, 0));
  endtask

  task automatic test_collide();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(0, 1, 0));
    idle(63);
    hold_rd(6'h08, d); chk("R10 ack value", d, img(3, 0));
    peek(6'h04, d); chk("R10 flag kept", d, 32'h1);
    peek(6'h0C, d); chk("R10 count one", d, img(1, 0));
  endtask

  task automatic test_readonly();
    logic [31:0] d;
    do_reset();
    wr(6'h00, mode(0, 1, 1));
    idle(20);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hFFFF_FFFF);
    peek(6'h04, d); chk("R11 flag unchanged", d, 32'h1);
    peek(6'h0C, d); chk("R11 count unchanged", d, img(1, 0));
    peek(6'h00, d); chk("R11 mode unchanged", d, mode(0, 1, 1));
    chk("R11 irq unchanged", {31'h0, irq}, 32'h1);
    peek(6'h10, d); chk("R11 unmapped 0x10", d, 32'h0);
    peek(6'h01, d); chk("R11 unmapped 0x01", d, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_tick();
    test_period();
    test_ack_image();
    test_disable();
    test_saturate();
    test_collide();
    test_readonly();
    finish_run();
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule